// File: doc/BRIEF.md
# USB Controller Interrupt Aggregation Wrapper

This block sits between a USB on-the-go controller core and a host CPU. It collects event pulses from the core into two 32-bit source words: one for endpoint events, one for core-level USB events. Software sees each word through a small register bus. Each word has a direct view, a write-one-to-set alias, a write-one-to-clear alias, an enable mask with its own set and clear aliases, and a read-only view of the source ANDed with the mask.

All enabled, pending bits are merged into one interrupt line. After the line has been taken, it stays quiet until software writes the end-of-interrupt register. This holds even if events are still pending or new ones arrive. A control bit gives a soft reset of all sources and masks. A nonzero revision constant lets software confirm that the block is clocked. The core, the PHY and VBUS sensing are outside the block. They appear only as event pulses and as one status level.

Top module: `usb_irq_wrap`

## Requirements
- R1: While `rst_n` is low, at a clock edge, every source and mask clears and the re-arm flag sets. After reset, `irq_out` is low and all source, mask and masked views read zero.
- R2: Offset 0x00 reads a fixed nonzero revision constant (default 0x0003_0501). Offset 0x08 reads the `vbus_drv_sts` input in bit 0, with zeros above it.
- R3: In the endpoint word (direct view 0x20), transmit endpoints 0..15 are bits 15:0 and receive endpoints 1..15 are bits 31:17. Bit 16 never holds a one, whether it comes from an event, a set alias or a mask write.
- R4: In the core word (direct view 0x40), only the 9-bit field at bits 24:16 can hold ones. The VBUS-drive-change event is bit 24.
- R5: The endpoint group uses these offsets: set 0x24, clear 0x28, mask 0x2C, mask set 0x30, mask clear 0x34. The core group uses the same layout at 0x44..0x54. A write to a set alias ORs the written ones in, and a write to a clear alias removes them. A write to a mask base replaces the mask. Writes to a source base (0x20/0x40) are ignored.
- R6: A one on an `ep_evt` or `core_evt` bit sets that source bit at the next edge. If a clear-alias write hits the same bit in the same cycle, the event wins.
- R7: Offsets 0x38 and 0x58 read source AND mask for the endpoint and core groups.
- R8: `irq_out` is high exactly when the re-arm flag is set and any masked bit is nonzero. The flag clears at the edge after `irq_out` is high, so the line gives one cycle of assertion. It sets again on a write to 0x60, whatever the data.
- R9: A write to control (0x04) with bit 0 set clears all sources and masks and sets the re-arm flag. This beats events in the same cycle. A write with bit 0 clear changes nothing. Control reads zero.
- R10: Reads of reserved, unaligned or unmapped offsets (for example 0x10, 0x5C, 0x7C, 0x21) return zero, and so do reads of the write-only aliases and 0x60. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset for the read and the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ep_evt | input | 32 | Endpoint event pulses, bit layout as in R3 |
| core_evt | input | 32 | Core event pulses, bit layout as in R4 |
| vbus_drv_sts | input | 1 | VBUS drive level shown in the status word |
| irq_out | output | 1 | Merged interrupt line |

## Verification
A wrong source or mask bit shows on the very next cycle in which the matching direct or masked view is addressed. It also shows in `irq_out` as soon as that bit is enabled. A wrong re-arm flag shows in the first cycle with a pending masked bit: either a missing one-cycle assertion, or an extra one before the end-of-interrupt write. The bench compares the read data and the interrupt line against a behavioural model on every clock. A fault therefore shows up within a cycle of the stimulus that exposes it.

// File: rtl/usb_irq_pkg.sv
// Package: register offsets and field layouts shared by the interrupt wrapper.
// Assumes byte addressing with 32-bit word-aligned registers.
package usb_irq_pkg;
    localparam int          REG_W          = 32;
    localparam logic [7:0]  OFS_REV        = 8'h00;
    localparam logic [7:0]  OFS_CTRL       = 8'h04;
    localparam logic [7:0]  OFS_STAT       = 8'h08;
    localparam logic [7:0]  OFS_GRP_BASE   = 8'h20;
    localparam logic [7:0]  OFS_GRP_STRIDE = 8'h20;
    localparam logic [7:0]  OFS_EOI        = 8'h60;
    // offsets inside one group
    localparam logic [7:0]  REL_SRC        = 8'h00;
    localparam logic [7:0]  REL_SRC_SET    = 8'h04;
    localparam logic [7:0]  REL_SRC_CLR    = 8'h08;
    localparam logic [7:0]  REL_MSK        = 8'h0C;
    localparam logic [7:0]  REL_MSK_SET    = 8'h10;
    localparam logic [7:0]  REL_MSK_CLR    = 8'h14;
    localparam logic [7:0]  REL_MASKED     = 8'h18;
    // bits that may hold state in each group
    localparam logic [31:0] EP_VALID       = 32'hFFFE_FFFF;
    localparam logic [31:0] CORE_VALID     = 32'h01FF_0000;
    localparam int          VBUS_DRV_BIT   = 24;
    localparam int          SRST_BIT       = 0;
endpackage

// File: rtl/irq_src_bank.sv
// Module: one interrupt group, a source word plus its enable mask.
// The source takes hardware event pulses and write-one-to-set or
// write-one-to-clear updates. The mask takes a direct write and set/clear
// updates. Only bits in VALID hold state. Assumes at most one write strobe
// per cycle, and that srst beats everything else.
module irq_src_bank #(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] VALID  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              src_set_we,
    input  logic              src_clr_we,
    input  logic              msk_we,
    input  logic              msk_set_we,
    input  logic              msk_clr_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt,
    output logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] msk,
    output logic [DATA_W-1:0] masked
);
    logic [DATA_W-1:0] src_nxt;
    logic [DATA_W-1:0] msk_nxt;
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;

    // Next source: set alias, then clear alias, then events (events win).
    always_comb begin
        set_bits = src_set_we ? wdata : '0;
        clr_bits = src_clr_we ? wdata : '0;
        src_nxt  = (((src | set_bits) & ~clr_bits) | evt) & VALID;
    end

    // Next mask: direct write, set alias or clear alias.
    always_comb begin
        msk_nxt = msk;
        if (msk_we)     msk_nxt = wdata;
        if (msk_set_we) msk_nxt = msk | wdata;
        if (msk_clr_we) msk_nxt = msk & ~wdata;
        msk_nxt = msk_nxt & VALID;
    end

    // State registers with reset and soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            src <= '0;
            msk <= '0;
        end else begin
            src <= src_nxt;
            msk <= msk_nxt;
        end
    end

    // Masked view offered to the read path and to the line logic.
    assign masked = src & msk;

    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && (evt & VALID) != '0) |=>
        ((src & $past(evt & VALID)) == $past(evt & VALID)));

    a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (src == '0 && msk == '0));

    a_r5_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr_we && !srst) |=> ((src & $past(wdata & ~evt)) == '0));
endmodule

// File: rtl/irq_arm_ctl.sv
// Module: merges pending state into one interrupt line, which fires once
// per arming. The flag drops after the line is high and is set again by
// an end-of-interrupt or a soft reset. Assumes `pending` comes from
// registered state.
module irq_arm_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi,
    input  logic srst,
    output logic irq_out
);
    logic armed;

    // Line is high only while armed with something pending.
    assign irq_out = armed & pending;

    // Re-arm flag: set by end-of-interrupt or soft reset, cleared once taken.
    always_ff @(posedge clk) begin
        if (!rst_n)            armed <= 1'b1;
        else if (eoi || srst)  armed <= 1'b1;
        else if (irq_out)      armed <= 1'b0;
    end

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !eoi && !srst) |=> !irq_out);

    a_r8_hold_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !eoi && !srst) |=> !armed);

    a_r8_eoi_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> armed);
endmodule

// File: rtl/usb_irq_wrap.sv
// Module: top of the interrupt aggregation wrapper. Decodes the register
// bus and instantiates one source bank per group (endpoint, core) plus the
// one-shot line control. Reads are combinational from bus_addr, and writes
// take effect at the clock edge where bus_wr is high.
module usb_irq_wrap
    import usb_irq_pkg::*;
#(
    parameter int                DATA_W    = REG_W,
    parameter int                ADDR_W    = 8,
    parameter logic [DATA_W-1:0] REV_VALUE = 32'h0003_0501
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] ep_evt,
    input  logic [DATA_W-1:0] core_evt,
    input  logic              vbus_drv_sts,
    output logic              irq_out
);
    localparam int NGRP = 2;

    logic [NGRP-1:0][DATA_W-1:0] src_w, msk_w, mskd_w, evt_w;
    logic                        srst;
    logic                        eoi;
    logic                        pending;

    assign evt_w[0] = ep_evt;
    assign evt_w[1] = core_evt;

    // Global control strobes decoded from the bus.
    assign srst = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[SRST_BIT];
    assign eoi  = bus_wr && (bus_addr == ADDR_W'(OFS_EOI));

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] BASE  =
            ADDR_W'(OFS_GRP_BASE + OFS_GRP_STRIDE * g);
        localparam logic [DATA_W-1:0] VALID = (g == 0) ? EP_VALID : CORE_VALID;
        irq_src_bank #(.DATA_W(DATA_W), .VALID(VALID)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .srst       (srst),
            .src_set_we (bus_wr && bus_addr == BASE + ADDR_W'(REL_SRC_SET)),
            .src_clr_we (bus_wr && bus_addr == BASE + ADDR_W'(REL_SRC_CLR)),
            .msk_we     (bus_wr && bus_addr == BASE + ADDR_W'(REL_MSK)),
            .msk_set_we (bus_wr && bus_addr == BASE + ADDR_W'(REL_MSK_SET)),
            .msk_clr_we (bus_wr && bus_addr == BASE + ADDR_W'(REL_MSK_CLR)),
            .wdata      (bus_wdata),
            .evt        (evt_w[g]),
            .src        (src_w[g]),
            .msk        (msk_w[g]),
            .masked     (mskd_w[g])
        );
    end

    // Any enabled pending bit in any group.
    always_comb begin
        pending = 1'b0;
        for (int g = 0; g < NGRP; g++) pending = pending | (|mskd_w[g]);
    end

    irq_arm_ctl u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .eoi     (eoi),
        .srst    (srst),
        .irq_out (irq_out)
    );

    // Read mux; anything not listed returns zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_REV))  bus_rdata = REV_VALUE;
        if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = DATA_W'(vbus_drv_sts);
        for (int g = 0; g < NGRP; g++) begin
            if (bus_addr == ADDR_W'(OFS_GRP_BASE + OFS_GRP_STRIDE * g + REL_SRC))
                bus_rdata = src_w[g];
            if (bus_addr == ADDR_W'(OFS_GRP_BASE + OFS_GRP_STRIDE * g + REL_MSK))
                bus_rdata = msk_w[g];
            if (bus_addr == ADDR_W'(OFS_GRP_BASE + OFS_GRP_STRIDE * g + REL_MASKED))
                bus_rdata = mskd_w[g];
        end
    end

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(8'h10) || bus_addr == ADDR_W'(8'h5C)) |-> (bus_rdata == '0));

    a_r4_vbus_only_field: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && core_evt[VBUS_DRV_BIT]) |=> src_w[1][VBUS_DRV_BIT]);
endmodule

// File: tb/sim_usb_irq_wrap.sv
`timescale 1ns/1ps
module sim_usb_irq_wrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ep_evt = '0;
    logic [31:0] core_evt = '0;
    logic        vbus_drv_sts = 1'b0;
    logic        irq_out;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural model state
    logic [31:0] m_sep = '0, m_mep = '0, m_sco = '0, m_mco = '0;
    bit          m_arm = 1'b1;
    localparam logic [31:0] EPV = 32'hFFFE_FFFF;
    localparam logic [31:0] COV = 32'h01FF_0000;
    localparam logic [31:0] REV = 32'h0003_0501;

    always #2.5 clk = ~clk;

    usb_irq_wrap u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_evt(ep_evt),
        .core_evt(core_evt), .vbus_drv_sts(vbus_drv_sts), .irq_out(irq_out)
    );

    function automatic logic m_irq();
        return m_arm && (((m_sep & m_mep) | (m_sco & m_mco)) != 0);
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return REV;
            8'h08: return {31'b0, vbus_drv_sts};
            8'h20: return m_sep;
            8'h2C: return m_mep;
            8'h38: return m_sep & m_mep;
            8'h40: return m_sco;
            8'h4C: return m_mco;
            8'h58: return m_sco & m_mco;
            default: return 32'h0;
        endcase
    endfunction

    // Model update on each edge, from the requirements.
    always @(posedge clk) begin
        logic fire;
        fire = m_irq();
        if (!rst_n) begin
            m_sep = 0; m_mep = 0; m_sco = 0; m_mco = 0; m_arm = 1;
        end else if (bus_wr && bus_addr == 8'h04 && bus_wdata[0]) begin
            m_sep = 0; m_mep = 0; m_sco = 0; m_mco = 0; m_arm = 1;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    8'h24: m_sep |= bus_wdata;
                    8'h28: m_sep &= ~bus_wdata;
                    8'h2C: m_mep = bus_wdata;
                    8'h30: m_mep |= bus_wdata;
                    8'h34: m_mep &= ~bus_wdata;
                    8'h44: m_sco |= bus_wdata;
                    8'h48: m_sco &= ~bus_wdata;
                    8'h4C: m_mco = bus_wdata;
                    8'h50: m_mco |= bus_wdata;
                    8'h54: m_mco &= ~bus_wdata;
                    default: ;
                endcase
            end
            m_sep = (m_sep | ep_evt) & EPV;
            m_sco = (m_sco | core_evt) & COV;
            m_mep &= EPV;
            m_mco &= COV;
            if (bus_wr && bus_addr == 8'h60) m_arm = 1;
            else if (fire)                    m_arm = 0;
        end
    end

    task automatic compare();
        logic [31:0] er;
        er = m_read(bus_addr);
        n_vec++;
        if (bus_rdata !== er) begin
            n_bad++;
            $display("FAIL %s rdata @%02h actual %08h expected %08h", cur_req, bus_addr, bus_rdata, er);
        end
        if (irq_out !== m_irq()) begin
            n_bad++;
            $display("FAIL %s irq_out actual %0b expected %0b", cur_req, irq_out, m_irq());
        end
    endtask

    // One cycle: check current outputs, then drive the next inputs.
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] e, input logic [31:0] c);
        @(negedge clk);
        compare();
        bus_wr = w; bus_addr = a; bus_wdata = d; ep_evt = e; core_evt = c;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 0, 0);
    endtask

    task automatic rd(input logic [7:0] a);
        step(1'b0, a, 0, 0, 0);
    endtask

    task automatic sweep();
        rd(8'h20); rd(8'h2C); rd(8'h38); rd(8'h40); rd(8'h4C); rd(8'h58);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep();
        // R2: revision and status
        cur_req = "R2";
        rd(8'h00); rd(8'h08);
        vbus_drv_sts = 1'b1; rd(8'h08); rd(8'h08);
        vbus_drv_sts = 1'b0; rd(8'h08);
        // R3: endpoint layout, bit 16 never stored
        cur_req = "R3";
        step(0, 8'h20, 0, 32'hFFFF_FFFF, 0);
        rd(8'h20); wr(8'h24, 32'h0001_0000); rd(8'h20);
        wr(8'h28, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF); rd(8'h20);
        wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C); rd(8'h38);
        wr(8'h2C, 0); wr(8'h28, 32'hFFFF_FFFF); wr(8'h60, 0); rd(8'h20);
        // R4: core field 24:16, VBUS drive at bit 24
        cur_req = "R4";
        step(0, 8'h40, 0, 0, 32'hFFFF_FFFF); rd(8'h40);
        wr(8'h48, 32'hFFFF_FFFF);
        step(0, 8'h40, 0, 0, 32'h0100_0000); rd(8'h40);
        wr(8'h4C, 32'h0100_0000); rd(8'h58); rd(8'h58);
        wr(8'h48, 32'h0100_0000); wr(8'h4C, 0); wr(8'h60, 0); sweep();
        // R5: aliases, mask base write, ignored source base write
        cur_req = "R5";
        wr(8'h20, 32'h0000_00FF); rd(8'h20);
        wr(8'h24, 32'h0000_0F0F); rd(8'h20); wr(8'h28, 32'h0000_0303); rd(8'h20);
        wr(8'h30, 32'h0000_00F0); rd(8'h2C); wr(8'h34, 32'h0000_0030); rd(8'h2C);
        wr(8'h2C, 32'hA000_0005); rd(8'h2C);
        wr(8'h44, 32'h0003_0000); rd(8'h40); wr(8'h50, 32'h0002_0000); rd(8'h4C);
        wr(8'h54, 32'h0002_0000); rd(8'h4C); wr(8'h40, 0); rd(8'h40);
        // R6: event beats a clear alias on the same bit
        cur_req = "R6";
        step(1, 8'h28, 32'hFFFF_FFFF, 32'h0000_0400, 0); rd(8'h20);
        step(1, 8'h48, 32'hFFFF_FFFF, 0, 32'h0080_0000); rd(8'h40);
        step(0, 8'h20, 0, 32'h8000_0001, 0); rd(8'h20);
        // R7: masked views
        cur_req = "R7";
        wr(8'h2C, 32'h8000_0400); rd(8'h38); wr(8'h50, 32'h0080_0000); rd(8'h58);
        // R8: one-shot line, EOI re-arms, data ignored
        cur_req = "R8";
        wr(8'h60, 32'h1234_5678); rd(8'h38); rd(8'h38);
        step(0, 8'h38, 0, 32'h0000_0002, 0); rd(8'h38); rd(8'h38);
        wr(8'h60, 32'hFFFF_FFFF); rd(8'h38); rd(8'h38);
        wr(8'h28, 32'hFFFF_FFFF); wr(8'h48, 32'hFFFF_FFFF); wr(8'h60, 0); rd(8'h38);
        step(0, 8'h58, 0, 0, 32'h0080_0000); rd(8'h58); rd(8'h58);
        wr(8'h60, 0); rd(8'h58);
        // R9: soft reset beats events, bit 0 clear is harmless
        cur_req = "R9";
        wr(8'h04, 32'hFFFF_FFFE); sweep(); rd(8'h04);
        step(1, 8'h04, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF); sweep();
        wr(8'h24, 32'h3); wr(8'h2C, 32'h1); rd(8'h38); rd(8'h38);
        wr(8'h04, 32'h1); sweep();
        // R10: unmapped and write-only offsets
        cur_req = "R10";
        rd(8'h10); rd(8'h5C); rd(8'h7C); rd(8'h21); rd(8'h24); rd(8'h60); rd(8'hFC);
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h5C, 32'hFFFF_FFFF); wr(8'h25, 32'hFFFF_FFFF);
        wr(8'h2D, 32'hFFFF_FFFF); wr(8'hF0, 32'hFFFF_FFFF); sweep(); rd(8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule